// File: doc/BRIEF.md
# Wiper and Initial-Value Register Controller

This block is the register core behind a dual digital potentiometer. Each of two channels owns a volatile 7-bit wiper code that drives the tap selection, plus a nonvolatile initial-value code that is loaded into the wiper at power-up. Five nonvolatile general-purpose bytes and one volatile access-control byte complete the register space. A serial front end decodes frames and presents each register request on a simple parallel port. It also signals the end of each frame with a one-cycle chip-select-rise strobe.

Each channel's wiper and initial-value registers share one address. A mode bit in the access-control byte picks which of the two is reached. In nonvolatile mode a write updates the wiper at once and stages the byte for nonvolatile storage. The staged byte is committed by a self-timed cycle that starts at the end of the frame and is reported as write-in-progress. After a soft reset both wipers sit at mid-scale. Once the recall enable arrives, the stored values are reloaded and the block starts accepting host requests. Nonvolatile state is cleared only by the power-on reset. Shutdown is the OR of an external active-low pin and a cleared control bit. The wiper codes are kept throughout shutdown.

Top module: `wiper_reg_ctrl`

## Requirements
- R1: While the soft reset is held, and after it until recall completes, both wiper outputs read 40h and ready_o is 0. The control byte returns to mode bit 0 and shutdown bit 1.
- R2: After recall_en_i is seen high, recall takes RECALL_CYC clocks. Then each wiper is loaded from its initial-value register, and ready_o goes to 1 and stays there.
- R3: Before ready_o is 1, read and write requests are ignored. They produce no read response and change no register.
- R4: A read of address 8 returns the control byte as {mode bit 7, shutdown bit 6, write-in-progress bit 5, 5'b0}. A write there sets bit 7 and bit 6 from the data.
- R5: With mode bit 1, a write to address 0 or 1 changes only that channel's wiper. A read of address 0 or 1 returns {1'b0, wiper}.
- R6: With mode bit 0, a write to address 0 or 1 updates the wiper in the next cycle. The same 7 bits go to the initial-value register when the nonvolatile cycle ends. A read returns {1'b0, initial value}.
- R7: A nonvolatile cycle starts on cs_rise_i only if a nonvolatile byte is staged. Write-in-progress reads 1 while the cycle runs and 0 after NV_CYC clocks.
- R8: While write-in-progress is 1, every write is dropped. This covers the wiper, initial-value, general-purpose and control registers.
- R9: Only one nonvolatile byte is staged per cycle. A later nonvolatile write before the cycle starts is dropped entirely.
- R10: Addresses 2 to 6 are nonvolatile general-purpose bytes. Each is written through a nonvolatile cycle and read back in full. Address 7 reads 0 and ignores writes.
- R11: Reading an initial-value register leaves the matching wiper code unchanged.
- R12: shutdown_o is 1 when shdn_pin_ni is 0 or the shutdown bit is 0. Register access and the wiper codes are unaffected.
- R13: Nonvolatile contents survive a soft reset, and the next recall loads them into the wipers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Soft reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset of nonvolatile contents, active low, asynchronous |
| recall_en_i | input | 1 | Supply is good enough to recall stored values |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 8 | Write data |
| cs_rise_i | input | 1 | One-cycle strobe marking the end of a frame |
| shdn_pin_ni | input | 1 | External shutdown pin, active low |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 8 | Read data |
| ready_o | output | 1 | Recall finished, requests accepted |
| wiper_o | output | 2x7 | Wiper codes per channel, 00h near ground, 7Fh near supply |
| shutdown_o | output | 1 | Resistor arrays in shutdown |

## Verification
Most corrupted internal state in this block shows up on the wiper outputs, either in the cycle after the write that caused it or at the next recall. Lost or misrouted nonvolatile bytes stay hidden until a read at the end of the nonvolatile cycle, or until a soft reset followed by recall. The bench therefore mixes immediate checks of the wiper codes with delayed read-backs. These read-backs cross a full write cycle and a reset. A stuck write-in-progress flag shows up as dropped writes, and it is also read directly from the control byte.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CODE_W = 7;
  localparam logic [ADDR_W-1:0] ACR_ADDR = 4'd8;
  localparam logic [CODE_W-1:0] MID_CODE = 7'h40;

  typedef struct packed {
    logic vol;
    logic shdn;
  } acr_t;

  typedef enum logic [1:0] {RC_WAIT, RC_LOAD, RC_DONE} rc_state_e;
endpackage

// File: rtl/wrc_nv_timer.sv
module wrc_nv_timer #(
  parameter int CYC = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(CYC - 1);
    end
  end

  AST_WIP_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R7
  AST_WIP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R7
endmodule

// File: rtl/wrc_recall.sv
module wrc_recall
  import wrc_pkg::*;
#(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recall_en_i,
  output logic load_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(CYC + 1);

  rc_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o  = (state_q == RC_LOAD) && (cnt_q == '0);
  assign ready_o = (state_q == RC_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RC_WAIT;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RC_WAIT: if (recall_en_i) begin
          state_q <= RC_LOAD;
          cnt_q   <= CNT_W'(CYC - 1);
        end
        RC_LOAD: if (cnt_q == '0) state_q <= RC_DONE;
                 else cnt_q <= cnt_q - 1'b1;
        default: state_q <= RC_DONE;
      endcase
    end
  end

  AST_READY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(load_o)); // R2
  AST_READY_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R2
endmodule

// File: rtl/wiper_reg_ctrl.sv
module wiper_reg_ctrl
  import wrc_pkg::*;
#(
  parameter int CH_N       = 2,
  parameter int GP_N       = 5,
  parameter int NV_CYC     = 5_000_000,
  parameter int RECALL_CYC = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         por_ni,
  input  logic                         recall_en_i,
  input  logic                         req_valid_i,
  input  logic                         req_write_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [DATA_W-1:0]            req_wdata_i,
  input  logic                         cs_rise_i,
  input  logic                         shdn_pin_ni,
  output logic                         rd_valid_o,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic                         ready_o,
  output logic [CH_N-1:0][CODE_W-1:0]  wiper_o,
  output logic                         shutdown_o
);
  localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int GP_W = (GP_N > 1) ? $clog2(GP_N) : 1;

  logic [CH_N-1:0][CODE_W-1:0] wiper_q, ivr_q;
  logic [GP_N-1:0][DATA_W-1:0] gp_q;
  acr_t                        acr_q;
  logic                        pend_q;
  logic [ADDR_W-1:0]           pend_addr_q;
  logic [DATA_W-1:0]           pend_data_q;
  logic                        wip, nv_done, load, ready;

  // address decode
  logic              is_ch, is_gp, is_acr;
  logic [CH_W-1:0]   ch_idx;
  logic [ADDR_W-1:0] gp_off, pend_gp_off;
  logic [GP_W-1:0]   gp_idx;
  logic              req_ok, wr_ok, nv_req, nv_take, vol_wr, acr_wr, start;

  assign is_ch   = req_addr_i < ADDR_W'(CH_N);
  assign is_gp   = !is_ch && (req_addr_i < ADDR_W'(CH_N + GP_N));
  assign is_acr  = req_addr_i == ACR_ADDR;
  assign ch_idx  = req_addr_i[CH_W-1:0];
  assign gp_off  = req_addr_i - ADDR_W'(CH_N);
  assign gp_idx  = gp_off[GP_W-1:0];

  assign req_ok  = req_valid_i && ready;
  assign wr_ok   = req_ok && req_write_i && !wip;
  assign nv_req  = wr_ok && ((is_ch && !acr_q.vol) || is_gp);
  assign nv_take = nv_req && !pend_q;
  assign vol_wr  = wr_ok && is_ch && (acr_q.vol || nv_take);
  assign acr_wr  = wr_ok && is_acr;
  assign start   = cs_rise_i && pend_q;

  wrc_recall #(.CYC(RECALL_CYC)) u_recall (
    .clk_i, .rst_ni, .recall_en_i,
    .load_o  (load),
    .ready_o (ready)
  );

  wrc_nv_timer #(.CYC(NV_CYC)) u_nv_timer (
    .clk_i, .rst_ni,
    .start_i (start),
    .busy_o  (wip),
    .done_o  (nv_done)
  );

  // staged nonvolatile byte, one per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (start) begin
      pend_q <= 1'b0;
    end else if (nv_take) begin
      pend_q      <= 1'b1;
      pend_addr_q <= req_addr_i;
      pend_data_q <= req_wdata_i;
    end
  end

  assign pend_gp_off = pend_addr_q - ADDR_W'(CH_N);

  // nonvolatile array: cleared only by power-on reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      ivr_q <= '0;
      gp_q  <= '0;
    end else if (nv_done) begin
      if (pend_addr_q < ADDR_W'(CH_N))
        ivr_q[pend_addr_q[CH_W-1:0]] <= pend_data_q[CODE_W-1:0];
      else
        gp_q[pend_gp_off[GP_W-1:0]] <= pend_data_q;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 wiper_q[c] <= MID_CODE;
      else if (load)                               wiper_q[c] <= ivr_q[c];
      else if (vol_wr && ch_idx == CH_W'(c))       wiper_q[c] <= req_wdata_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acr_q.vol  <= 1'b0;
      acr_q.shdn <= 1'b1;
    end else if (acr_wr) begin
      acr_q.vol  <= req_wdata_i[7];
      acr_q.shdn <= req_wdata_i[6];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (is_ch)       rd_mux = {1'b0, acr_q.vol ? wiper_q[ch_idx] : ivr_q[ch_idx]};
    else if (is_gp)  rd_mux = gp_q[gp_idx];
    else if (is_acr) rd_mux = {acr_q.vol, acr_q.shdn, wip, 5'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= req_ok && !req_write_i;
      if (req_ok && !req_write_i) rd_data_o <= rd_mux;
    end
  end

  assign ready_o    = ready;
  assign wiper_o    = wiper_q;
  assign shutdown_o = !shdn_pin_ni || !acr_q.shdn;

  AST_MID_UNTIL_RECALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (wiper_q == {CH_N{MID_CODE}})); // R1
  AST_RECALL_LOADS_IVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> (wiper_q == ivr_q)); // R2
  AST_NO_READ_BEFORE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(ready)); // R3
  AST_WIPER_FROZEN_IN_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && $past(ready) && !$stable(wiper_q)) |-> !$past(wip)); // R8
  AST_ONE_NV_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !wip); // R9
endmodule

// File: tb/tb_wiper_reg_ctrl.sv
module tb_wiper_reg_ctrl;
  localparam int NV_CYC = 40;
  localparam int RC_CYC = 8;

  logic       clk = 1'b0;
  logic       rst_n, por_n, recall_en;
  logic       req_valid, req_write, cs_rise, shdn_pin_n;
  logic [3:0] req_addr;
  logic [7:0] req_wdata;
  logic       rd_valid, ready, shutdown;
  logic [7:0] rd_data;
  logic [1:0][6:0] wiper;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  wiper_reg_ctrl #(.NV_CYC(NV_CYC), .RECALL_CYC(RC_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .recall_en_i(recall_en),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .cs_rise_i(cs_rise), .shdn_pin_ni(shdn_pin_n),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ready_o(ready),
    .wiper_o(wiper), .shutdown_o(shutdown)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_ignored(logic [3:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cs_pulse();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rd_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R3: unexpected read response actual %0h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; por_n = 0; recall_en = 0; req_valid = 0; req_write = 0;
    req_addr = '0; req_wdata = '0; cs_rise = 0; shdn_pin_n = 1;
    idle(3);
    rst_n = 1; por_n = 1;
    idle(2);
    // R1 reset state
    check("R1 wiper0", wiper[0], 7'h40);
    check("R1 wiper1", wiper[1], 7'h40);
    check("R1 ready", ready, 0);
    check("R1 shutdown", shutdown, 0);
    // R3 requests before recall are ignored
    wr(4'd8, 8'hC0);
    wr(4'd1, 8'h33);
    rd_ignored(4'd8);
    check("R3 wiper1 untouched", wiper[1], 7'h40);
    // R2 recall
    recall_en = 1;
    idle(RC_CYC + 3);
    check("R2 ready", ready, 1);
    check("R2 wiper0 from ivr", wiper[0], 7'h00);
    check("R2 wiper1 from ivr", wiper[1], 7'h00);
    rd(4'd8, 8'h40, "R4 acr default, R3 write ignored");
    // R5 volatile-only write
    wr(4'd8, 8'hC0);
    wr(4'd1, 8'h25);
    check("R5 wiper1", wiper[1], 7'h25);
    rd(4'd1, 8'h25, "R5 read wiper1");
    wr(4'd8, 8'h40);
    rd(4'd1, 8'h00, "R5 ivr1 unchanged");
    cs_pulse();
    rd(4'd8, 8'h40, "R7 no cycle without staged byte");
    // R6 nonvolatile write, R9 second byte dropped
    wr(4'd0, 8'h77);
    check("R6 wiper0 immediate", wiper[0], 7'h77);
    rd(4'd0, 8'h00, "R6 ivr0 not yet committed");
    wr(4'd3, 8'hAB);
    cs_pulse();
    rd(4'd8, 8'h60, "R7 wip set");
    // R8 writes rejected during cycle
    wr(4'd8, 8'hC0);
    wr(4'd1, 8'h11);
    check("R8 wiper1 frozen", wiper[1], 7'h25);
    idle(NV_CYC + 4);
    rd(4'd8, 8'h40, "R7 wip clear, R8 acr write dropped");
    rd(4'd0, 8'h77, "R6 ivr0 committed");
    rd(4'd3, 8'h00, "R9 second nv byte dropped");
    // R10 general-purpose and reserved
    wr(4'd5, 8'h5A);
    cs_pulse();
    idle(NV_CYC + 4);
    rd(4'd5, 8'h5A, "R10 gp byte");
    wr(4'd7, 8'hFF);
    rd(4'd7, 8'h00, "R10 reserved reads zero");
    rd(4'd8, 8'h40, "R10 reserved write staged nothing");
    // R11 reading ivr leaves wiper alone
    wr(4'd8, 8'hC0);
    wr(4'd0, 8'h10);
    wr(4'd8, 8'h40);
    rd(4'd0, 8'h77, "R11 ivr0 read");
    check("R11 wiper0 kept", wiper[0], 7'h10);
    // R12 shutdown
    shdn_pin_n = 0;
    idle(1);
    check("R12 pin shutdown", shutdown, 1);
    check("R12 wiper0 kept", wiper[0], 7'h10);
    shdn_pin_n = 1;
    idle(1);
    check("R12 pin release", shutdown, 0);
    wr(4'd8, 8'h00);
    check("R12 bit shutdown", shutdown, 1);
    rd(4'd5, 8'h5A, "R12 access in shutdown");
    rd(4'd8, 8'h00, "R4 acr bits written");
    wr(4'd8, 8'h40);
    check("R12 bit release", shutdown, 0);
    check("R12 wiper1 kept", wiper[1], 7'h25);
    // R13 soft reset keeps nonvolatile contents
    recall_en = 0;
    idle(1);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(3);
    check("R1 wiper0 mid after soft reset", wiper[0], 7'h40);
    check("R1 ready low after soft reset", ready, 0);
    recall_en = 1;
    idle(RC_CYC + 3);
    check("R13 wiper0 recalled", wiper[0], 7'h77);
    check("R13 wiper1 recalled", wiper[1], 7'h00);
    rd(4'd5, 8'h5A, "R13 gp survives");
    idle(4);
    check("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule